// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block runs one SPI flash command cycle at a time on behalf of a host. The host never sends opcodes directly. It first loads an eight-entry opcode menu, a two-entry prefix table and a 16-bit type field that gives each menu entry two flags: "has address" and "needs prefix". To start a cycle it writes a control word. The word picks a menu entry and a prefix entry, gives a data byte count and a direction, and sets the data-enable, atomic and go bits.

For each cycle the engine drives the serial pins in SPI mode 0. When the atomic bit is set, it first sends the chosen prefix opcode in a chip-select frame of its own. It then sends the main frame: the opcode, an optional 24-bit address and an optional data phase. Write data comes from a 64-byte buffer. Read data is stored into the same buffer. Status flags report busy, done and blocked. The host register port is a plain single-cycle write/read port with no back-pressure. A write takes effect on the clock edge at which `wr_en` is high. Reads are combinational. The serial clock runs at the system clock divided by the even parameter `DIV`.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, chip select is high, SCLK is low, and the status word and the configuration registers read as zero.
- R2: Every byte is sent most significant bit first in SPI mode 0: SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on each rising edge. The main frame starts with the menu byte selected by control bits [6:4]. Menu entries 0–3 sit in register 4 and entries 4–7 sit in register 5, with entry k in byte k mod 4.
- R3: When type bit 2i of the selected entry i is set, the opcode is followed by the 24-bit address register (register 2), upper byte first. The address is captured when the cycle starts.
- R4: When the atomic bit (control bit 1) is set, the prefix byte chosen by control bit 7 (register 6, entry j in byte j) is sent alone in its own frame. Chip select then returns high for `DIV` clocks, and the main frame follows.
- R5: For a write cycle (control bit 3 clear) with data enable (control bit 2) set, buffer bytes 0..N-1 are sent after the address. N-1 is held in control bits [13:8]. The write leaves the buffer unchanged.
- R6: For a read cycle (control bit 3 set) with data enable set, the engine sends N zero bytes and stores the received bytes into buffer bytes 0..N-1. Buffer word w sits at register address 16+w, with byte 4w+b in bits [8b+7:8b].
- R7: With data enable clear there is no data phase, and the buffer is not modified, even when the read bit is set.
- R8: A go whose selected entry has type bit 2i+1 (needs prefix) set while the atomic bit is clear starts no frame. It sets status bit 2 (blocked) and raises no done pulse.
- R9: Status register 1 holds busy in bit 0 (read-only), done in bit 1 and blocked in bit 2. Writing 1 to bit 1 or bit 2 clears that bit. When chip select rises at the end of the final frame, `cycle_done` pulses for exactly one clock and done is set.
- R10: A go written while a cycle is in progress is ignored. It sends no extra frame, raises no extra done pulse and leaves the running cycle unchanged.
- R11: One SCLK period lasts `DIV` system clocks, with `DIV/2` clocks low and `DIV/2` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address (0–6 registers, 16–31 buffer words) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Combinational read data |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| cycle_done | output | 1 | One-clock pulse at the end of a cycle |
| busy | output | 1 | Cycle in progress |

## Verification
The bench targets the cases where several frame pieces join or drop out: prefix-plus-address-plus-data write frames, an address-less prefixed command, and read cycles with and without an address phase. A design that mixed up the type bits would add or drop the three address bytes. A design that sent the prefix inside the main frame would produce one long frame where two short ones are expected. It checks that a read stores bytes from buffer index 0 only after the address phase; an off-by-one there shifts every stored byte. It also checks that data-enable-clear reads leave the buffer untouched, that a forbidden unprefixed write is blocked without any chip-select activity, and that a second go during a busy cycle neither restarts nor queues a frame. Each of these faults would show up as an unexpected serial byte, a wrong frame length or a stray done pulse.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
  localparam int BUF_BYTES = 64;
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int WIDX_W    = $clog2(BUF_WORDS);
  localparam int RA_W      = WIDX_W + 1;
  localparam int BIDX_W    = $clog2(BUF_BYTES);
  localparam int MENU_N    = 8;
  localparam int PFX_N     = 2;
  localparam int MIDX_W    = $clog2(MENU_N);
  localparam int PIDX_W    = $clog2(PFX_N);
  localparam int TYPE_W    = 2 * MENU_N;
  localparam int ADDR_BITS = 24;

  // register word addresses below the buffer window
  localparam int RA_CTRL    = 0;
  localparam int RA_STAT    = 1;
  localparam int RA_ADDR    = 2;
  localparam int RA_TYPE    = 3;
  localparam int RA_MENU_LO = 4;
  localparam int RA_MENU_HI = 5;
  localparam int RA_PFX     = 6;

  localparam int ST_BUSY_B = 0;
  localparam int ST_DONE_B = 1;
  localparam int ST_BLK_B  = 2;

  localparam int TY_ADDR = 0;
  localparam int TY_PFX  = 1;

  typedef struct packed {
    logic [BIDX_W-1:0] last;
    logic [PIDX_W-1:0] pidx;
    logic [MIDX_W-1:0] midx;
    logic              rd;
    logic              den;
    logic              atomic;
    logic              go;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_GAP, ST_FIN} seq_state_t;
  typedef enum logic [1:0] {PH_PRE, PH_OP, PH_ADDR, PH_DATA} seq_phase_t;
endpackage

// File: rtl/spi_seq_shifter.sv
`timescale 1ns/1ps
module spi_seq_shifter #(
  parameter int DIV = 4,
  localparam int HALF = DIV / 2,
  localparam int HW = $clog2(HALF) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx,
  output logic       busy
);
  logic [HW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;

  assign mosi = busy ? sh[7] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sh <= '0; bitn <= '0; sclk <= 1'b0;
      done <= 1'b0; rx <= '0; busy <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; sh <= tx; cnt <= '0; bitn <= '0; sclk <= 1'b0;
        end
      end else if (cnt == HW'(HALF - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + HW'(1);
      end
    end
  end

  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  p_mosi_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_half_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < HW'(HALF));
endmodule

// File: rtl/spi_seq_regs.sv
`timescale 1ns/1ps
module spi_seq_regs
  import spi_seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [RA_W-1:0]         wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [RA_W-1:0]         rd_addr,
  output logic [31:0]             rd_data,
  input  logic                    eng_busy,
  input  logic                    eng_done,
  input  logic                    eng_blocked,
  output logic                    go,
  output ctrl_t                   ctrl,
  output logic [MENU_N*8-1:0]     menu,
  output logic [PFX_N*8-1:0]      pfx,
  output logic [TYPE_W-1:0]       type_bits,
  output logic [ADDR_BITS-1:0]    addr,
  input  logic [BIDX_W-1:0]       buf_ridx,
  output logic [7:0]              buf_rbyte,
  input  logic                    buf_we,
  input  logic [BIDX_W-1:0]       buf_widx,
  input  logic [7:0]              buf_wbyte
);
  logic [7:0] mem [BUF_BYTES];
  logic       sts_done, sts_blk;
  logic       reg_wr;

  assign reg_wr    = wr_en && !wr_addr[RA_W-1];
  assign go        = reg_wr && (int'(wr_addr[WIDX_W-1:0]) == RA_CTRL) && wr_data[0];
  assign ctrl      = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign buf_rbyte = mem[buf_ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0; type_bits <= '0; menu <= '0; pfx <= '0;
      sts_done <= 1'b0; sts_blk <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (int'(wr_addr[WIDX_W-1:0]))
          RA_ADDR:    addr <= wr_data[ADDR_BITS-1:0];
          RA_TYPE:    type_bits <= wr_data[TYPE_W-1:0];
          RA_MENU_LO: menu[31:0] <= wr_data;
          RA_MENU_HI: menu[63:32] <= wr_data;
          RA_PFX:     pfx <= wr_data[PFX_N*8-1:0];
          RA_STAT: begin
            if (wr_data[ST_DONE_B]) sts_done <= 1'b0;
            if (wr_data[ST_BLK_B])  sts_blk  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (eng_done)    sts_done <= 1'b1;
      if (eng_blocked) sts_blk  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
    end else begin
      if (wr_en && wr_addr[RA_W-1])
        for (int b = 0; b < 4; b++) mem[{wr_addr[WIDX_W-1:0], 2'(b)}] <= wr_data[8*b +: 8];
      if (buf_we) mem[buf_widx] <= buf_wbyte;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[RA_W-1]) begin
      for (int b = 0; b < 4; b++) rd_data[8*b +: 8] = mem[{rd_addr[WIDX_W-1:0], 2'(b)}];
    end else begin
      case (int'(rd_addr[WIDX_W-1:0]))
        RA_STAT: begin
          rd_data[ST_BUSY_B] = eng_busy;
          rd_data[ST_DONE_B] = sts_done;
          rd_data[ST_BLK_B]  = sts_blk;
        end
        RA_ADDR:    rd_data[ADDR_BITS-1:0] = addr;
        RA_TYPE:    rd_data[TYPE_W-1:0] = type_bits;
        RA_MENU_LO: rd_data = menu[31:0];
        RA_MENU_HI: rd_data = menu[63:32];
        RA_PFX:     rd_data[PFX_N*8-1:0] = pfx;
        default:    rd_data = '0;
      endcase
    end
  end

  p_done_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> sts_done);
  p_block_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_blocked |=> sts_blk);
endmodule

// File: rtl/spi_seq_fsm.sv
`timescale 1ns/1ps
module spi_seq_fsm
  import spi_seq_pkg::*;
#(
  parameter int GAP_CYC = 4,
  localparam int GAP_W = $clog2(GAP_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  ctrl_t                 ctrl_in,
  input  logic [MENU_N*8-1:0]   menu,
  input  logic [PFX_N*8-1:0]    pfx,
  input  logic [TYPE_W-1:0]     type_bits,
  input  logic [ADDR_BITS-1:0]  addr,
  output logic [BIDX_W-1:0]     buf_ridx,
  input  logic [7:0]            buf_rbyte,
  output logic                  buf_we,
  output logic [BIDX_W-1:0]     buf_widx,
  output logic [7:0]            buf_wbyte,
  output logic                  sh_start,
  output logic [7:0]            sh_tx,
  input  logic                  sh_done,
  input  logic [7:0]            sh_rx,
  output logic                  cs_n,
  output logic                  busy,
  output logic                  done_o,
  output logic                  blocked_o
);
  seq_state_t             st;
  seq_phase_t             ph;
  ctrl_t                  cur;
  logic [1:0]             cur_ty;
  logic [1:0]             ty_in;
  logic [ADDR_BITS-1:0]   cur_addr;
  logic [BIDX_W-1:0]      idx;
  logic [GAP_W-1:0]       gap;

  assign ty_in     = type_bits[2*ctrl_in.midx +: 2];
  assign busy      = (st != ST_IDLE);
  assign sh_start  = (st == ST_SEND);
  assign buf_ridx  = idx;
  assign buf_widx  = idx;
  assign buf_wbyte = sh_rx;
  assign buf_we    = (st == ST_WAIT) && sh_done && (ph == PH_DATA) && cur.rd;

  always_comb begin
    case (ph)
      PH_PRE:  sh_tx = pfx[8*cur.pidx +: 8];
      PH_OP:   sh_tx = menu[8*cur.midx +: 8];
      PH_ADDR: sh_tx = 8'(cur_addr >> (16 - 8*int'(idx)));
      default: sh_tx = cur.rd ? 8'h00 : buf_rbyte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_OP; cur <= '0; cur_ty <= '0; cur_addr <= '0;
      idx <= '0; gap <= '0; cs_n <= 1'b1; done_o <= 1'b0; blocked_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      blocked_o <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          if (ty_in[TY_PFX] && !ctrl_in.atomic) begin
            blocked_o <= 1'b1;
          end else begin
            cur      <= ctrl_in;
            cur_ty   <= ty_in;
            cur_addr <= addr;
            idx      <= '0;
            ph       <= ctrl_in.atomic ? PH_PRE : PH_OP;
            cs_n     <= 1'b0;
            st       <= ST_SEND;
          end
        end
        ST_SEND: st <= ST_WAIT;
        ST_WAIT: if (sh_done) begin
          st  <= ST_SEND;
          idx <= idx + BIDX_W'(1);
          case (ph)
            PH_PRE: begin
              ph <= PH_OP; idx <= '0; cs_n <= 1'b1; gap <= '0; st <= ST_GAP;
            end
            PH_OP: begin
              idx <= '0;
              if (cur_ty[TY_ADDR]) ph <= PH_ADDR;
              else if (cur.den)    ph <= PH_DATA;
              else                 st <= ST_FIN;
            end
            PH_ADDR: if (idx == BIDX_W'(2)) begin
              idx <= '0;
              if (cur.den) ph <= PH_DATA;
              else         st <= ST_FIN;
            end
            default: if (idx == cur.last) st <= ST_FIN;
          endcase
        end
        ST_GAP: begin
          if (gap == GAP_W'(GAP_CYC - 1)) begin
            cs_n <= 1'b0;
            st   <= ST_SEND;
          end else begin
            gap <= gap + GAP_W'(1);
          end
        end
        ST_FIN: begin
          cs_n   <= 1'b1;
          done_o <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_idle_cs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> cs_n);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_block_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_o |-> (cs_n && st == ST_IDLE));
  p_go_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && st != ST_IDLE) |=> $stable(cur));
endmodule

// File: rtl/spi_cmd_seq.sv
`timescale 1ns/1ps
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [RA_W-1:0] rd_addr,
  output logic [31:0]     rd_data,
  output logic            spi_cs_n,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic            spi_miso,
  output logic            cycle_done,
  output logic            busy
);
  logic                 go, eng_blocked, buf_we, sh_start, sh_done, sh_busy;
  ctrl_t                ctrl;
  logic [MENU_N*8-1:0]  menu;
  logic [PFX_N*8-1:0]   pfx;
  logic [TYPE_W-1:0]    type_bits;
  logic [ADDR_BITS-1:0] addr;
  logic [BIDX_W-1:0]    buf_ridx, buf_widx;
  logic [7:0]           buf_rbyte, buf_wbyte, sh_tx, sh_rx;

  spi_seq_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .eng_busy(busy), .eng_done(cycle_done), .eng_blocked(eng_blocked),
    .go, .ctrl, .menu, .pfx, .type_bits, .addr,
    .buf_ridx, .buf_rbyte, .buf_we, .buf_widx, .buf_wbyte
  );

  spi_seq_fsm #(.GAP_CYC(DIV)) u_fsm (
    .clk, .rst_n, .go, .ctrl_in(ctrl), .menu, .pfx, .type_bits, .addr,
    .buf_ridx, .buf_rbyte, .buf_we, .buf_widx, .buf_wbyte,
    .sh_start, .sh_tx, .sh_done, .sh_rx,
    .cs_n(spi_cs_n), .busy, .done_o(cycle_done), .blocked_o(eng_blocked)
  );

  spi_seq_shifter #(.DIV(DIV)) u_shift (
    .clk, .rst_n, .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx), .busy(sh_busy)
  );

  p_shift_inside_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !spi_cs_n);
endmodule

// File: tb/test_spi_cmd_seq.sv
`timescale 1ns/1ps
module test_spi_cmd_seq;
  import spi_seq_pkg::*;
  localparam int DIV = 4;
  localparam int CLK_NS = 5;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, miso = 1'b0;
  logic [RA_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  wire cs_n, sclk, mosi, cycle_done, busy;

  spi_cmd_seq #(.DIV(DIV)) i_spi_cmd_seq (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
    .cycle_done, .busy
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, nbits = 0, frames = 0, dones = 0;
  logic [7:0] cur = '0, rbyte;
  logic [7:0] exp_b[$];
  int exp_len[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'hC3 + 8'(k * 7);
  endfunction

  // flash model: drives MISO and acts as the scoreboard monitor
  always @(negedge cs_n) begin nbits = 0; rbyte = resp(0); miso = rbyte[7]; end
  always @(negedge sclk) if (!cs_n) begin rbyte = resp(nbits / 8); miso = rbyte[7 - (nbits % 8)]; end
  always @(posedge sclk) if (!cs_n) begin
    cur = {cur[6:0], mosi};
    nbits++;
    if (nbits % 8 == 0) begin
      if (exp_b.size() == 0) check("R10 unexpected serial byte", {24'd0, cur}, 32'hFFFF_FFFF);
      else check("R2 serial byte", {24'd0, cur}, {24'd0, exp_b.pop_front()});
    end
  end
  always @(posedge cs_n) if (rst_n) begin
    frames++;
    if (exp_len.size() == 0) check("R8 unexpected frame", 32'(nbits / 8), 32'hFFFF_FFFF);
    else check("R4 frame length", 32'(nbits), 32'(exp_len.pop_front() * 8));
  end
  always @(negedge clk) if (cycle_done) dones++;

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = RA_W'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_addr = RA_W'(a); #1; d = rd_data;
  endtask

  task automatic push(input logic [7:0] b); exp_b.push_back(b); endtask

  task automatic wait_done();
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (cycle_done) return;
    end
    check("R9 cycle_done timeout", 32'd0, 32'd1);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    check("watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int d0, f0;
    time t0, t1;
    repeat (4) @(negedge clk);
    #1 check("R1 pins after reset", {30'd0, cs_n, sclk}, 32'h2);
    rst_n = 1'b1;
    rd(RA_STAT, v); check("R1 status after reset", v, 32'h0);
    rd(RA_TYPE, v); check("R1 type after reset", v, 32'h0);

    wr(RA_MENU_LO, 32'h9f05_0b03);
    wr(RA_MENU_HI, 32'h01d8_2002);
    wr(RA_PFX, 32'h0000_0650);
    wr(RA_TYPE, 32'h0000_BF05);

    // R2 R6 R11: entry 2, no address, read 2 bytes
    d0 = dones;
    push(8'h05); push(8'h00); push(8'h00); exp_len.push_back(3);
    wr(RA_CTRL, 32'h12D);
    @(posedge sclk) t0 = $time;
    @(posedge sclk) t1 = $time;
    check("R11 sclk period", 32'(t1 - t0), 32'(DIV * CLK_NS));
    wait_done();
    rd(16, v); check("R6 read bytes no address", {16'd0, v[15:0]}, 32'h0000_D1CA);
    rd(RA_STAT, v); check("R9 done set", v, 32'h2);
    check("R9 one done pulse", 32'(dones - d0), 32'd1);
    wr(RA_STAT, 32'h1); rd(RA_STAT, v); check("R9 busy bit not writable", v, 32'h2);
    wr(RA_STAT, 32'h2); rd(RA_STAT, v); check("R9 done cleared", v, 32'h0);

    // R3 R6: entry 0 with address, read 4 bytes
    wr(RA_ADDR, 32'h0012_3456);
    push(8'h03); push(8'h12); push(8'h34); push(8'h56);
    for (int i = 0; i < 4; i++) push(8'h00);
    exp_len.push_back(8);
    wr(RA_CTRL, 32'h30D);
    repeat (10) @(negedge clk);
    rd(RA_STAT, v); check("R9 busy during cycle", {31'd0, v[0]}, 32'h1);
    wait_done();
    rd(16, v); check("R6 read bytes after address", v, 32'hF4ED_E6DF);

    // R4 R5: atomic program, prefix 1, 3 data bytes
    wr(16, 32'hCCBB_AA11);
    wr(RA_ADDR, 32'h0000_ABCD);
    push(8'h06); exp_len.push_back(1);
    push(8'h02); push(8'h00); push(8'hAB); push(8'hCD);
    push(8'h11); push(8'hAA); push(8'hBB); exp_len.push_back(7);
    wr(RA_CTRL, 32'h2C7);
    wait_done();
    rd(16, v); check("R5 buffer kept after write", v, 32'hCCBB_AA11);

    // R7: erase with read bit but no data phase
    push(8'h50); exp_len.push_back(1);
    push(8'h20); push(8'h00); push(8'hAB); push(8'hCD); exp_len.push_back(4);
    wr(RA_CTRL, 32'h5B);
    wait_done();
    rd(16, v); check("R7 buffer untouched erase", v, 32'hCCBB_AA11);
    push(8'h9f); exp_len.push_back(1);
    wr(RA_CTRL, 32'h39);
    wait_done();
    rd(16, v); check("R7 buffer untouched id", v, 32'hCCBB_AA11);

    // R4: entry 7 prefixed, no address, 1 data byte
    push(8'h50); exp_len.push_back(1);
    push(8'h01); push(8'h11); exp_len.push_back(2);
    wr(RA_CTRL, 32'h77);
    wait_done();
    wr(RA_STAT, 32'h6);

    // R8: prefixed entry without atomic is blocked
    d0 = dones; f0 = frames;
    wr(RA_CTRL, 32'h61);
    repeat (100) @(negedge clk);
    rd(RA_STAT, v); check("R8 blocked flag", v, 32'h4);
    check("R8 no frame", 32'(frames - f0), 32'd0);
    check("R8 no done pulse", 32'(dones - d0), 32'd0);
    wr(RA_STAT, 32'h4); rd(RA_STAT, v); check("R9 blocked cleared", v, 32'h0);

    // R10: go while busy
    d0 = dones; f0 = frames;
    push(8'h9f); exp_len.push_back(1);
    wr(RA_CTRL, 32'h31);
    repeat (3) @(negedge clk);
    wr(RA_CTRL, 32'h12D);
    wait_done();
    repeat (200) @(negedge clk);
    check("R10 single frame", 32'(frames - f0), 32'd1);
    check("R10 single done", 32'(dones - d0), 32'd1);

    check("R2 all bytes seen", 32'(exp_b.size()), 32'd0);
    check("R4 all frames seen", 32'(exp_len.size()), 32'd0);
    finish_run();
  end
endmodule